// File: doc/BRIEF.md
# Shared Flash Cycle-Stealing Arbiter

This block lets two masters read from one external flash (or ROM, or SRAM) device. The first master is an embedded controller that fetches its firmware. The second is a host processor that reads its BIOS. The controller owns the flash bus by default. When the host has a request pending, the arbiter steals the next slot between controller accesses for it. Both masters therefore keep executing from the same device, with their accesses interleaved.

A host access is flagged by a memory chip-select input together with a 19-bit host address. The three upper lines of that address select a 64 KB bank, which gives a 512 KB window. The window maps onto the lower part of the flash address space. The host is told to wait through a ready line that is low from chip-select assertion until its word is valid.

Until the controller reports that it has booted, a host reset output stays asserted. While that reset is asserted, host chip-select is ignored, so the host cannot reach the flash. Every flash access occupies a slot of `LAT` clock cycles, and the read data is taken in the last cycle of the slot.

Top module: `shflash_arb`

## Requirements
- R1: While `rst_n` is low, the outputs settle to these values: `host_rst_o`=1, `fl_oe`=0, `ctl_ack`=0 and `host_rdy`=1.
- R2: `host_rst_o` falls in the cycle after `boot_done` is first sampled high. It then stays low whatever `boot_done` does afterwards.
- R3: While `host_rst_o` is high, `host_sel` has no effect. No host flash slot runs, `fl_oe` stays low if the controller is idle, and `host_rdy` stays high.
- R4: Every slot holds `fl_oe`=1 with a stable `fl_addr` for exactly `LAT` cycles. A controller slot drives `ctl_addr` and returns the flash word on `ctl_rdata`, with `ctl_ack`=1 in the slot's last cycle. The controller holds `ctl_req` and `ctl_addr` until it sees `ctl_ack`.
- R5: A host read is driven on `fl_addr` as `host_addr` zero-extended to `AW` bits, so bits 18:16 choose the 64 KB bank. `host_rdy` is low while `host_sel` is high and the word is not yet ready. `host_rdy` rises in the cycle after the host slot ends, and `host_rdata` then holds the flash word.
- R6: Once `host_rdy` is high with `host_sel` high, both `host_rdy` and `host_rdata` stay unchanged until `host_sel` goes low. A new host read needs `host_sel` to go low and then high again.
- R7: If `ctl_req` is high when a host slot ends, the next slot goes to the controller. The host never gets two slots in a row while the controller is waiting.
- R8: A pending host request is granted no later than the slot that follows one controller slot. `host_rdy` therefore returns high within 2·`LAT`+1 cycles of `host_sel` rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_done | input | 1 | Controller has finished booting (latched) |
| host_rst_o | output | 1 | Host reset; fences the host off the flash |
| ctl_req | input | 1 | Controller fetch request, held until ack |
| ctl_addr | input | AW | Controller flash address |
| ctl_ack | output | 1 | Controller data valid, last slot cycle |
| ctl_rdata | output | DW | Controller read data |
| host_sel | input | 1 | Host memory chip-select, active high |
| host_addr | input | 19 | Host address, bits 18:16 are the bank lines |
| host_rdy | output | 1 | Host ready; low means wait |
| host_rdata | output | DW | Host read data, held while selected |
| fl_oe | output | 1 | Flash read strobe |
| fl_addr | output | AW | Flash address |
| fl_rdata | input | DW | Flash read data |

## Verification
The bench builds the block with `LAT`=3, `AW`=20 and `DW`=16. With three-cycle slots, the bench's flash model can return garbage in any cycle before the last one of a slot, so a slot that is too short or an address that moves during a slot shows up as a wrong word. `AW`=20 leaves one flash address bit above the host window, and the bench drives all eight host banks. Long bursts of controller fetches run against host re-requests, which makes it possible to observe the one-steal rule and the bound on host wait time.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_CTL  = 2'd1,
    SLOT_HOST = 2'd2
  } slot_e;
endpackage

// File: rtl/sfa_host_port.sv
module sfa_host_port #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_done,
  input  logic          host_sel,
  input  logic          host_busy,
  input  logic          host_end,
  input  logic [DW-1:0] fl_rdata,
  output logic          host_rst_o,
  output logic          host_pend,
  output logic          host_rdy,
  output logic [DW-1:0] host_rdata
);
  logic          boot_q, boot_d, boot_en;
  logic          done_q, done_d, done_en;
  logic [DW-1:0] data_q;
  logic          data_en;

  always_comb begin
    boot_en = boot_done & ~boot_q;
    boot_d  = 1'b1;
    done_en = ~host_sel | host_end;
    done_d  = host_sel & host_end;
    data_en = host_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (boot_en) boot_q <= boot_d;
      if (done_en) done_q <= done_d;
      if (data_en) data_q <= fl_rdata;
    end
  end

  assign host_rst_o = ~boot_q;
  assign host_pend  = boot_q & host_sel & ~done_q & ~host_busy;
  assign host_rdy   = ~(boot_q & host_sel & ~done_q);
  assign host_rdata = data_q;

  p_fence_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rst_o |=> !host_rst_o);
  p_rdy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdy && host_sel) |=> (host_rdy || !host_sel));
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdy && host_sel && !host_rst_o) |=> (!host_sel || $stable(host_rdata)));
endmodule

// File: rtl/sfa_slot_sched.sv
module sfa_slot_sched
  import sfa_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctl_req,
  input  logic  host_pend,
  output slot_e slot,
  output logic  last,
  output logic  grant_ctl,
  output logic  grant_host
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(LAT - 1);

  slot_e         state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          steal_q, steal_d;
  logic          busy, can_start, ctl_ok, tick_en;

  always_comb begin
    busy      = (state_q != SLOT_IDLE);
    last      = busy && (cnt_q == CNT_LAST);
    can_start = !busy || last;
    ctl_ok    = ctl_req && (state_q != SLOT_CTL);
    grant_ctl  = 1'b0;
    grant_host = 1'b0;
    if (can_start) begin
      if (ctl_ok && (steal_q || !host_pend)) grant_ctl = 1'b1;
      else if (host_pend)                    grant_host = 1'b1;
    end
    state_d = state_q;
    cnt_d   = cnt_q;
    steal_d = steal_q;
    if (grant_ctl) begin
      state_d = SLOT_CTL;
      cnt_d   = '0;
      steal_d = 1'b0;
    end else if (grant_host) begin
      state_d = SLOT_HOST;
      cnt_d   = '0;
      steal_d = 1'b1;
    end else if (last) begin
      state_d = SLOT_IDLE;
      cnt_d   = '0;
    end else if (busy) begin
      cnt_d = cnt_q + CW'(1);
    end
    tick_en = busy || grant_ctl || grant_host;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_IDLE;
      cnt_q   <= '0;
      steal_q <= 1'b0;
    end else if (tick_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      steal_q <= steal_d;
    end
  end

  assign slot = state_q;

  p_slot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> $stable(state_q));
  p_one_steal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLOT_HOST && last && ctl_req) |=> (state_q == SLOT_CTL));
  p_grant_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_ctl && grant_host));
endmodule

// File: rtl/shflash_arb.sv
module shflash_arb
  import sfa_pkg::*;
#(
  parameter int AW  = 20,
  parameter int DW  = 16,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_done,
  output logic          host_rst_o,
  input  logic          ctl_req,
  input  logic [AW-1:0] ctl_addr,
  output logic          ctl_ack,
  output logic [DW-1:0] ctl_rdata,
  input  logic          host_sel,
  input  logic [18:0]   host_addr,
  output logic          host_rdy,
  output logic [DW-1:0] host_rdata,
  output logic          fl_oe,
  output logic [AW-1:0] fl_addr,
  input  logic [DW-1:0] fl_rdata
);
  localparam int HAW = 19;
  localparam int PAD = AW - HAW;

  slot_e         slot;
  logic          last, grant_ctl, grant_host, host_pend;
  logic          host_busy, host_end;
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  sfa_slot_sched #(.LAT(LAT)) u_sched (
    .clk(clk), .rst_n(rst_n), .ctl_req(ctl_req), .host_pend(host_pend),
    .slot(slot), .last(last), .grant_ctl(grant_ctl), .grant_host(grant_host)
  );

  assign host_busy = (slot == SLOT_HOST);
  assign host_end  = host_busy && last;

  sfa_host_port #(.DW(DW)) u_host (
    .clk(clk), .rst_n(rst_n), .boot_done(boot_done), .host_sel(host_sel),
    .host_busy(host_busy), .host_end(host_end), .fl_rdata(fl_rdata),
    .host_rst_o(host_rst_o), .host_pend(host_pend), .host_rdy(host_rdy),
    .host_rdata(host_rdata)
  );

  always_comb begin
    addr_en = grant_ctl | grant_host;
    addr_d  = grant_host ? {{PAD{1'b0}}, host_addr} : ctl_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign fl_oe     = (slot != SLOT_IDLE);
  assign fl_addr   = addr_q;
  assign ctl_ack   = (slot == SLOT_CTL) && last;
  assign ctl_rdata = fl_rdata;

  p_ack_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ack |-> ctl_req);
  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_oe && !last) |=> (fl_oe && $stable(fl_addr)));
  p_fence_no_host_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_rst_o |-> (slot != SLOT_HOST));
  p_host_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_busy |-> (fl_addr[AW-1:HAW] == '0));
endmodule

// File: tb/shflash_arb_tb.sv
module shflash_arb_tb_top;
  localparam int AW  = 20;
  localparam int DW  = 16;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          boot_done = 1'b0;
  logic          host_rst_o;
  logic          ctl_req = 1'b0;
  logic [AW-1:0] ctl_addr = '0;
  logic          ctl_ack;
  logic [DW-1:0] ctl_rdata;
  logic          host_sel = 1'b0;
  logic [18:0]   host_addr = '0;
  logic          host_rdy;
  logic [DW-1:0] host_rdata;
  logic          fl_oe;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  shflash_arb #(.AW(AW), .DW(DW), .LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .boot_done(boot_done), .host_rst_o(host_rst_o),
    .ctl_req(ctl_req), .ctl_addr(ctl_addr), .ctl_ack(ctl_ack), .ctl_rdata(ctl_rdata),
    .host_sel(host_sel), .host_addr(host_addr), .host_rdy(host_rdy),
    .host_rdata(host_rdata), .fl_oe(fl_oe), .fl_addr(fl_addr), .fl_rdata(fl_rdata)
  );

  // Behavioural memory: content is a function of the address. The model
  // returns valid data only once the address has been held for LAT-1 edges.
  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return a[15:0] ^ {a[19:16], a[19:16], a[19:16], a[19:16]} ^ 16'h3C5A;
  endfunction

  logic [AW-1:0] m_addr;
  int            m_run;
  always @(posedge clk) begin
    if (fl_oe && (fl_addr == m_addr) && m_run > 0) m_run <= m_run + 1;
    else if (fl_oe)                                m_run <= 1;
    else                                           m_run <= 0;
    m_addr <= fl_addr;
  end
  always_comb begin
    if (fl_oe && (m_run >= LAT - 1) && (fl_addr == m_addr || LAT == 1))
      fl_rdata = mem_word(fl_addr);
    else
      fl_rdata = 16'hDEAD;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Scoreboard queues
  logic [DW-1:0] ctl_q[$];
  logic [DW-1:0] host_q[$];
  bit host_seen = 1'b0;
  bit prev_host = 1'b0;
  bit ctl_gap   = 1'b0;
  int acks_since_host = 0;

  // Monitor: pops expected words as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ctl_req) ctl_gap = 1'b1;
      if (ctl_ack) begin
        acks_since_host++;
        if (ctl_q.size() == 0) chk(1'b0, "R4", "unexpected ctl_ack", 1, 0);
        else begin
          logic [DW-1:0] e;
          e = ctl_q.pop_front();
          chk(ctl_rdata == e, "R4", "ctl word", ctl_rdata, e);
        end
      end
      if (!host_rst_o && host_sel && host_rdy && !host_seen) begin
        host_seen = 1'b1;
        if (host_q.size() == 0) chk(1'b0, "R5", "unexpected host ready", 1, 0);
        else begin
          logic [DW-1:0] e;
          e = host_q.pop_front();
          chk(host_rdata == e, "R5", "host word", host_rdata, e);
        end
        // R7: with the controller waiting throughout, a controller slot
        // must separate two host completions
        if (prev_host && !ctl_gap)
          chk(acks_since_host >= 1, "R7", "ctl acks between host slots",
              acks_since_host, 1);
        prev_host = 1'b1;
        acks_since_host = 0;
        ctl_gap = 1'b0;
      end
      if (!host_sel) host_seen = 1'b0;
    end
  end

  // Driver: controller fetch. Entered and left just after a rising edge.
  task automatic ctl_read(input logic [AW-1:0] a, input bit keep);
    ctl_req  = 1'b1;
    ctl_addr = a;
    ctl_q.push_back(mem_word(a));
    @(negedge clk);
    while (!ctl_ack) @(negedge clk);
    @(posedge clk); #1;
    if (!keep) ctl_req = 1'b0;
  endtask

  task automatic host_read(input logic [18:0] a);
    int lat;
    logic [DW-1:0] got;
    @(posedge clk); #1;
    host_sel  = 1'b1;
    host_addr = a;
    host_q.push_back(mem_word({1'b0, a}));
    lat = 0;
    @(negedge clk);
    while (!host_rdy) begin
      lat++;
      @(negedge clk);
    end
    chk(lat <= 2 * LAT + 1, "R8", "host wait cycles", lat, 2 * LAT + 1);
    chk(lat >= LAT, "R5", "host_rdy low through slot", lat, LAT);
    got = host_rdata;
    repeat (2) begin
      @(negedge clk);
      chk(host_rdy && host_rdata == got, "R6", "host data held",
          host_rdata, got);
    end
    @(posedge clk); #1;
    host_sel = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(host_rst_o == 1'b1, "R1", "host_rst_o in reset", host_rst_o, 1);
    chk(fl_oe == 1'b0,      "R1", "fl_oe in reset", fl_oe, 0);
    chk(ctl_ack == 1'b0,    "R1", "ctl_ack in reset", ctl_ack, 0);
    chk(host_rdy == 1'b1,   "R1", "host_rdy in reset", host_rdy, 1);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R3: host chip-select during the boot fence is ignored
    @(posedge clk); #1;
    host_sel  = 1'b1;
    host_addr = 19'h5_1234;
    repeat (10) begin
      @(negedge clk);
      chk(fl_oe == 1'b0 && host_rdy == 1'b1, "R3", "fenced host ignored",
          {fl_oe, host_rdy}, 2'b01);
    end
    @(posedge clk); #1;
    ctl_read(20'h0_0042, 1'b0);
    @(negedge clk);
    chk(host_rdy == 1'b1 && host_rst_o == 1'b1, "R3", "fence holds after ctl read",
        {host_rdy, host_rst_o}, 2'b11);
    @(posedge clk); #1;
    host_sel = 1'b0;

    // R2: boot_done releases the host reset for good
    @(posedge clk); #1;
    boot_done = 1'b1;
    @(negedge clk);
    chk(host_rst_o == 1'b1, "R2", "reset before edge", host_rst_o, 1);
    @(posedge clk); #1;
    boot_done = 1'b0;
    @(negedge clk);
    chk(host_rst_o == 1'b0, "R2", "reset released", host_rst_o, 0);
    repeat (5) @(negedge clk);
    chk(host_rst_o == 1'b0, "R2", "reset stays released", host_rst_o, 0);

    // R4: controller alone, back-to-back and spaced
    @(posedge clk); #1;
    for (int i = 0; i < 20; i++)
      ctl_read(AW'(i * 20'h0_1F3B + 7), (i % 4) != 3);
    ctl_req = 1'b0;

    // R5: host alone, every bank on A18..A16
    for (int b = 0; b < 8; b++)
      host_read({b[2:0], 16'(b * 16'h1357 + 16'h0A0)});

    // R7/R8: contention
    @(posedge clk); #1;
    fork
      begin
        for (int i = 0; i < 150; i++)
          ctl_read(AW'($urandom), (i % 25) != 24);
        ctl_req = 1'b0;
      end
      begin
        for (int i = 0; i < 40; i++) host_read(19'($urandom));
      end
    join

    repeat (10) @(negedge clk);
    chk(ctl_q.size() == 0,  "R4", "ctl scoreboard drained", ctl_q.size(), 0);
    chk(host_q.size() == 0, "R5", "host scoreboard drained", host_q.size(), 0);
    chk(fl_oe == 1'b0, "R4", "bus idle at end", fl_oe, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule